// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block is the reservation logic inside an L1 data cache controller. It holds at most one reserved cache-line address. A load-reserved access records the line of its address. A store-conditional access is judged against that record. The block asks for exclusive permission when the line is not already held in the modified state, and it drops the record whenever a matching line leaves the cache. The data arrays and the coherence messaging sit outside; the block only talks to them through a hit-in-modified flag, an upgrade request/done handshake and a write strobe for a successful conditional store.

Requests are taken one at a time: `req_ready` is high whenever no permission upgrade is pending. Any number of eviction ports (replacement, invalidation, downgrade) report departing lines every cycle. Responses appear one cycle after the request, or one cycle after `upg_done` for a conditional store that had to wait for permission.

Top module: `lrsc_resv_tracker`

## Requirements
- R1: After reset the reservation is invalid, `req_ready` is 1, and `upg_req`, `rsp_valid` and `wr_en` are 0.
- R2: A load-reserved request (`req_op`=2) gives a response with `rsp_op`=2 and `rsp_fail`=0 one cycle later, and sets `resv_valid`=1 with `resv_line` = `req_addr` >> OFF_W.
- R3: A store-conditional (`req_op`=3) with no valid reservation, or with a reservation for a different line, responds one cycle later with `rsp_fail`=1, leaves `wr_en` at 0 and never raises `upg_req`.
- R4: A store-conditional that matches the reservation while `lookup_hit_m`=1 responds one cycle later with `rsp_fail`=0, pulsing `wr_en` with `wr_addr`=`req_addr` and `wr_data`=`req_wdata` in that same cycle.
- R5: A store-conditional that matches while `lookup_hit_m`=0 raises `upg_req` with `upg_line` = its line one cycle later, holds it and keeps `req_ready`=0 until `upg_done`; one cycle after `upg_done` it responds with `rsp_fail`=0 and the write if the reservation is still valid.
- R6: If the reservation is lost while the upgrade is pending, the store-conditional ends with `rsp_fail`=1 and no write.
- R7: Every store-conditional leaves the reservation invalid once its response is given, whether it succeeded or failed.
- R8: A valid eviction on any port whose line equals the reserved line clears the reservation on the next edge; an eviction of another line leaves it unchanged.
- R9: An eviction in the same cycle as a reservation check (request cycle or `upg_done` cycle) is applied first, so the store-conditional fails.
- R10: Plain loads (`req_op`=0) and stores (`req_op`=1) leave the reservation unchanged and respond with `rsp_fail`=0; a new load-reserved replaces an existing reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_op | input | 2 | 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data for a conditional store |
| lookup_hit_m | input | 1 | Tag lookup hit with modified permission |
| evict_valid | input | NUM_EVICT | Per-port eviction strobe |
| evict_line | input | NUM_EVICT*LINE_W | Per-port departing line, port 0 in the low bits |
| upg_req | output | 1 | Exclusive permission wanted |
| upg_line | output | LINE_W | Line for the upgrade |
| upg_done | input | 1 | Exclusive permission granted |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 2 | Operation being answered |
| rsp_fail | output | 1 | Conditional store status: 1 failed, 0 succeeded |
| wr_en | output | 1 | Write strobe for a successful conditional store |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| resv_valid | output | 1 | Reservation held |
| resv_line | output | LINE_W | Reserved line |

## Verification
Conditional stores are driven against each state of the reservation: none, another line, the same line through a hit in modified state, and the same line through an upgrade; these tell the immediate-fail path, the single-check path and the two-check path apart. Evictions are placed before the store, during the upgrade wait, and in the exact cycle of each check, on both ports and with both matching and non-matching lines, which separates the eviction-first ordering from a check that samples stale state. Plain accesses and back-to-back load-reserved requests between those show that only load-reserved, conditional stores and matching evictions touch the record.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        MOP_LOAD  = 2'd0,
        MOP_STORE = 2'd1,
        MOP_LR    = 2'd2,
        MOP_SC    = 2'd3
    } mop_e;

    typedef enum logic {
        SCS_IDLE     = 1'b0,
        SCS_WAIT_UPG = 1'b1
    } scs_e;

    localparam logic SC_STATUS_OK   = 1'b0;
    localparam logic SC_STATUS_FAIL = 1'b1;

    typedef struct packed {
        logic valid;
        mop_e op;
        logic fail;
    } rsp_s;

    function automatic logic is_cond_store(input logic [1:0] op);
        return mop_e'(op) == MOP_SC;
    endfunction

    function automatic logic is_load_resv(input logic [1:0] op);
        return mop_e'(op) == MOP_LR;
    endfunction

endpackage

// File: rtl/lrsc_evict_match.sv
module lrsc_evict_match #(
    parameter int LINE_W    = 26,
    parameter int NUM_EVICT = 2
) (
    input  logic [NUM_EVICT-1:0]        evict_valid,
    input  logic [NUM_EVICT*LINE_W-1:0] evict_line,
    input  logic                        resv_valid,
    input  logic [LINE_W-1:0]           resv_line,
    output logic                        kill
);
    logic [NUM_EVICT-1:0] port_hit;

    for (genvar p = 0; p < NUM_EVICT; p++) begin : g_port
        always_comb begin
            port_hit[p] = evict_valid[p]
                        && (evict_line[p*LINE_W +: LINE_W] == resv_line);
        end
    end

    assign kill = resv_valid && (|port_hit);
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [LINE_W-1:0] set_line,
    input  logic              clr_en,
    input  logic              evict_kill,
    output logic              valid,
    output logic [LINE_W-1:0] line
);
    // A new reservation wins over any clear in the same cycle:
    // the line being loaded by the reserving access stays in the cache.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            line  <= '0;
        end else if (set_en) begin
            valid <= 1'b1;
            line  <= set_line;
        end else if (clr_en || evict_kill) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lrsc_sc_ctrl.sv
module lrsc_sc_ctrl
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 6,
    parameter int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              lookup_hit_m,
    input  logic              upg_done,
    input  logic              resv_live,
    input  logic [LINE_W-1:0] resv_line,
    output logic              req_ready,
    output logic              set_en,
    output logic [LINE_W-1:0] set_line,
    output logic              clr_en,
    output logic              upg_req,
    output logic [LINE_W-1:0] upg_line,
    output rsp_s              rsp,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    scs_e              state_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    rsp_s              rsp_q;
    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    logic              fire;
    logic              fire_sc;
    logic [LINE_W-1:0] req_line;
    logic [LINE_W-1:0] pend_line;
    logic              first_ok;
    logic              second_ok;
    logic              need_upg;
    logic              done_now;
    logic              done_wait;
    logic              sc_success;

    always_comb begin
        req_line   = req_addr[ADDR_W-1:OFF_W];
        pend_line  = pend_addr_q[ADDR_W-1:OFF_W];
        req_ready  = (state_q == SCS_IDLE);
        fire       = req_valid && req_ready;
        fire_sc    = fire && is_cond_store(req_op);
        // resv_live already has same-cycle evictions removed
        first_ok   = resv_live && (resv_line == req_line);
        second_ok  = resv_live && (resv_line == pend_line);
        need_upg   = fire_sc && first_ok && !lookup_hit_m;
        done_now   = fire_sc && !need_upg;
        done_wait  = (state_q == SCS_WAIT_UPG) && upg_done;
        sc_success = (done_now && first_ok) || (done_wait && second_ok);
        set_en     = fire && is_load_resv(req_op);
        set_line   = req_line;
        clr_en     = done_now || done_wait;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SCS_IDLE;
            pend_addr_q <= '0;
            pend_data_q <= '0;
        end else begin
            case (state_q)
                SCS_IDLE: begin
                    if (need_upg) begin
                        state_q     <= SCS_WAIT_UPG;
                        pend_addr_q <= req_addr;
                        pend_data_q <= req_wdata;
                    end
                end
                SCS_WAIT_UPG: begin
                    if (upg_done) begin
                        state_q <= SCS_IDLE;
                    end
                end
                default: state_q <= SCS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q     <= '{valid: 1'b0, op: MOP_LOAD, fail: SC_STATUS_OK};
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            rsp_q.valid <= (fire && !need_upg) || done_wait;
            rsp_q.op    <= done_wait ? MOP_SC : mop_e'(req_op);
            rsp_q.fail  <= (clr_en && !sc_success) ? SC_STATUS_FAIL : SC_STATUS_OK;
            wr_en_q     <= sc_success;
            if (sc_success) begin
                wr_addr_q <= done_wait ? pend_addr_q : req_addr;
                wr_data_q <= done_wait ? pend_data_q : req_wdata;
            end
        end
    end

    assign upg_req  = (state_q == SCS_WAIT_UPG);
    assign upg_line = pend_line;
    assign rsp      = rsp_q;
    assign wr_en    = wr_en_q;
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;
endmodule

// File: rtl/lrsc_resv_tracker.sv
module lrsc_resv_tracker
    import lrsc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int OFF_W     = 6,
    parameter int NUM_EVICT = 2,
    parameter int LINE_W    = ADDR_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_op,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic                        lookup_hit_m,
    input  logic [NUM_EVICT-1:0]        evict_valid,
    input  logic [NUM_EVICT*LINE_W-1:0] evict_line,
    output logic                        upg_req,
    output logic [LINE_W-1:0]           upg_line,
    input  logic                        upg_done,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_op,
    output logic                        rsp_fail,
    output logic                        wr_en,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [DATA_W-1:0]           wr_data,
    output logic                        resv_valid,
    output logic [LINE_W-1:0]           resv_line
);
    logic              evict_kill;
    logic              resv_live;
    logic              set_en;
    logic [LINE_W-1:0] set_line;
    logic              clr_en;
    rsp_s              rsp;

    lrsc_evict_match #(
        .LINE_W    (LINE_W),
        .NUM_EVICT (NUM_EVICT)
    ) u_match (
        .evict_valid (evict_valid),
        .evict_line  (evict_line),
        .resv_valid  (resv_valid),
        .resv_line   (resv_line),
        .kill        (evict_kill)
    );

    assign resv_live = resv_valid && !evict_kill;

    lrsc_resv_reg #(
        .LINE_W (LINE_W)
    ) u_resv (
        .clk        (clk),
        .rst        (rst),
        .set_en     (set_en),
        .set_line   (set_line),
        .clr_en     (clr_en),
        .evict_kill (evict_kill),
        .valid      (resv_valid),
        .line       (resv_line)
    );

    lrsc_sc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .LINE_W (LINE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .lookup_hit_m (lookup_hit_m),
        .upg_done     (upg_done),
        .resv_live    (resv_live),
        .resv_line    (resv_line),
        .req_ready    (req_ready),
        .set_en       (set_en),
        .set_line     (set_line),
        .clr_en       (clr_en),
        .upg_req      (upg_req),
        .upg_line     (upg_line),
        .rsp          (rsp),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_op    = rsp.op;
    assign rsp_fail  = rsp.fail;
endmodule

// File: rtl/lrsc_resv_tracker_chk.sv
module lrsc_resv_tracker_chk #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 6,
    parameter int NUM_EVICT = 2,
    parameter int LINE_W    = ADDR_W - OFF_W
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [1:0]                  req_op,
    input logic [ADDR_W-1:0]           req_addr,
    input logic                        lookup_hit_m,
    input logic [NUM_EVICT-1:0]        evict_valid,
    input logic [NUM_EVICT*LINE_W-1:0] evict_line,
    input logic                        upg_req,
    input logic [LINE_W-1:0]           upg_line,
    input logic                        upg_done,
    input logic                        rsp_valid,
    input logic [1:0]                  rsp_op,
    input logic                        rsp_fail,
    input logic                        wr_en,
    input logic                        resv_valid,
    input logic [LINE_W-1:0]           resv_line
);
    logic rst_seen = 1'b0;
    logic ev_hit;
    logic fire;

    always_comb begin
        ev_hit = 1'b0;
        for (int p = 0; p < NUM_EVICT; p++) begin
            if (evict_valid[p] && evict_line[p*LINE_W +: LINE_W] == resv_line)
                ev_hit = 1'b1;
        end
        fire = req_valid && req_ready;
    end

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen && !rst) begin
            AST_RESET_CLEAN: assert (!resv_valid && !upg_req && !rsp_valid && !wr_en); // R1
        end
    end

    AST_LR_SETS_LINE: assert property (@(posedge clk) disable iff (rst)
        fire && req_op == 2'd2 |=> resv_valid && resv_line == $past(req_addr[ADDR_W-1:OFF_W])); // R2

    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fail |-> !wr_en); // R3

    AST_WRITE_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> rsp_valid && rsp_op == 2'd3 && !rsp_fail); // R4

    AST_UPG_HOLD: assert property (@(posedge clk) disable iff (rst)
        upg_req && !upg_done |=> upg_req && $stable(upg_line)); // R5

    AST_BUSY_DURING_UPG: assert property (@(posedge clk) disable iff (rst)
        upg_req |-> !req_ready); // R5

    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_op == 2'd3 |-> !resv_valid); // R7

    AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        resv_valid && ev_hit && !(fire && req_op == 2'd2) |=> !resv_valid); // R8

    AST_NO_UPG_WITHOUT_RESV: assert property (@(posedge clk) disable iff (rst)
        fire && req_op == 2'd3 && (!resv_valid || ev_hit) |=> !upg_req); // R3

    AST_HIT_M_NO_UPG: assert property (@(posedge clk) disable iff (rst)
        fire && req_op == 2'd3 && lookup_hit_m |=> !upg_req && rsp_valid); // R4
endmodule

bind lrsc_resv_tracker lrsc_resv_tracker_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .NUM_EVICT (NUM_EVICT),
    .LINE_W    (LINE_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .lookup_hit_m (lookup_hit_m),
    .evict_valid  (evict_valid),
    .evict_line   (evict_line),
    .upg_req      (upg_req),
    .upg_line     (upg_line),
    .upg_done     (upg_done),
    .rsp_valid    (rsp_valid),
    .rsp_op       (rsp_op),
    .rsp_fail     (rsp_fail),
    .wr_en        (wr_en),
    .resv_valid   (resv_valid),
    .resv_line    (resv_line)
);

// File: tb/lrsc_resv_tracker_bench.sv
module lrsc_resv_tracker_bench;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int OFF_W     = 6;
    localparam int NUM_EVICT = 2;
    localparam int LINE_W    = ADDR_W - OFF_W;

    typedef struct {
        logic [1:0]        op;
        logic              fail;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic lookup_hit_m = 1'b0;
    logic [NUM_EVICT-1:0] evict_valid = '0;
    logic [NUM_EVICT*LINE_W-1:0] evict_line = '0;
    logic upg_req;
    logic [LINE_W-1:0] upg_line;
    logic upg_done = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_op;
    logic rsp_fail;
    logic wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic resv_valid;
    logic [LINE_W-1:0] resv_line;

    int total = 0;
    int bad = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    lrsc_resv_tracker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .NUM_EVICT(NUM_EVICT)
    ) u_lrsc_resv_tracker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .lookup_hit_m(lookup_hit_m), .evict_valid(evict_valid),
        .evict_line(evict_line), .upg_req(upg_req), .upg_line(upg_line),
        .upg_done(upg_done), .rsp_valid(rsp_valid), .rsp_op(rsp_op),
        .rsp_fail(rsp_fail), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .resv_valid(resv_valid), .resv_line(resv_line)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    // monitor: pops expectations as responses arrive
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "unexpected response", rsp_op, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_op == e.op, {e.tag, " op"}, rsp_op, e.op);
                check(rsp_fail == e.fail, {e.tag, " status"}, rsp_fail, e.fail);
                check(wr_en == e.wr, {e.tag, " write strobe"}, wr_en, e.wr);
                if (e.wr) begin
                    check(wr_addr == e.addr, {e.tag, " write addr"}, wr_addr, e.addr);
                    check(wr_data == e.data, {e.tag, " write data"}, wr_data, e.data);
                end
            end
        end
    end

    // driver: one request for one cycle, optional same-cycle evictions
    task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic hit_m,
                         input logic [NUM_EVICT-1:0] ev,
                         input logic [LINE_W-1:0] ev0, input logic [LINE_W-1:0] ev1,
                         input logic upgrades, input logic efail, input logic ewr,
                         input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        lookup_hit_m = hit_m; evict_valid = ev; evict_line = {ev1, ev0};
        if (!upgrades) begin
            e.op = op; e.fail = efail; e.wr = ewr; e.addr = a; e.data = d; e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0; lookup_hit_m = 1'b0; evict_valid = '0;
    endtask

    task automatic finish_upg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                              input logic [NUM_EVICT-1:0] ev, input logic [LINE_W-1:0] ev0,
                              input logic efail, input string tag);
        exp_t e;
        upg_done = 1'b1; evict_valid = ev; evict_line = {{LINE_W{1'b0}}, ev0};
        e.op = 2'd3; e.fail = efail; e.wr = !efail; e.addr = a; e.data = d; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        upg_done = 1'b0; evict_valid = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!resv_valid, "R1 resv_valid", resv_valid, 0);
        check(req_ready, "R1 req_ready", req_ready, 1);
        check(!upg_req && !rsp_valid && !wr_en, "R1 outputs idle", {upg_req, rsp_valid, wr_en}, 0);

        // R3 conditional store without reservation, tag miss: no upgrade
        issue(2'd3, 32'h1000, 32'h11, 1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b0, "R3 no-resv");
        check(!upg_req, "R3 no upgrade", upg_req, 0);

        // R2 load-reserved
        issue(2'd2, 32'h1000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr");
        check(resv_valid && resv_line == line_of(32'h1000), "R2 resv_line", resv_line, line_of(32'h1000));

        // R10 plain accesses leave it
        issue(2'd0, 32'h2000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R10 load");
        issue(2'd1, 32'h2004, 5, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R10 store");
        check(resv_valid && resv_line == line_of(32'h1000), "R10 resv kept", resv_line, line_of(32'h1000));

        // R3 other line fails, R7 clears
        issue(2'd3, 32'h2000, 32'h22, 1'b1, '0, '0, '0, 1'b0, 1'b1, 1'b0, "R3 other-line");
        check(!resv_valid, "R7 cleared after fail", resv_valid, 0);

        // R4 hit in modified
        issue(2'd2, 32'h1004, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr2");
        issue(2'd3, 32'h1008, 32'hA5A5, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b1, "R4 hit-m");
        check(!resv_valid, "R7 cleared after success", resv_valid, 0);

        // R10 replacement
        issue(2'd2, 32'h3000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R10 lr-a");
        issue(2'd2, 32'h4000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R10 lr-b");
        check(resv_line == line_of(32'h4000), "R10 replaced", resv_line, line_of(32'h4000));
        issue(2'd3, 32'h3000, 32'h33, 1'b1, '0, '0, '0, 1'b0, 1'b1, 1'b0, "R10 old line fails");

        // R5 upgrade path success
        issue(2'd2, 32'h5000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr3");
        issue(2'd3, 32'h5010, 32'h5555, 1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0, "R5 miss");
        check(upg_req && upg_line == line_of(32'h5000), "R5 upg_line", upg_line, line_of(32'h5000));
        check(!req_ready, "R5 busy", req_ready, 0);
        repeat (3) @(negedge clk);
        check(upg_req && !rsp_valid, "R5 still waiting", rsp_valid, 0);
        finish_upg(32'h5010, 32'h5555, '0, '0, 1'b0, "R5 upgraded");
        check(!resv_valid && req_ready, "R7 cleared after upgrade", resv_valid, 0);

        // R6/R8 eviction during upgrade, port 1
        issue(2'd2, 32'h6000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr4");
        issue(2'd3, 32'h6000, 32'h66, 1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0, "R6 miss");
        evict_valid = 2'b10; evict_line = {line_of(32'h6000), {LINE_W{1'b0}}};
        @(negedge clk);
        evict_valid = '0;
        check(!resv_valid, "R8 port1 evict clears", resv_valid, 0);
        @(negedge clk);
        finish_upg(32'h6000, 32'h66, '0, '0, 1'b1, "R6 lost during upgrade");

        // R8 non-matching then matching on port 0
        issue(2'd2, 32'h7000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr5");
        evict_valid = 2'b01; evict_line = {line_of(32'h7000) ^ 26'h1, line_of(32'h7040)};
        @(negedge clk);
        check(resv_valid, "R8 other line kept", resv_valid, 1);
        evict_valid = 2'b01; evict_line = {{LINE_W{1'b0}}, line_of(32'h7000)};
        @(negedge clk);
        evict_valid = '0;
        check(!resv_valid, "R8 port0 evict clears", resv_valid, 0);

        // R9 same-cycle eviction at first check
        issue(2'd2, 32'h8000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr6");
        issue(2'd3, 32'h8000, 32'h88, 1'b1, 2'b01, line_of(32'h8000), '0, 1'b0, 1'b1, 1'b0, "R9 evict at check");
        check(!upg_req, "R9 no upgrade", upg_req, 0);

        // R9 same-cycle eviction at second check
        issue(2'd2, 32'h9000, 0, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R2 lr7");
        issue(2'd3, 32'h9000, 32'h99, 1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0, "R9 miss");
        finish_upg(32'h9000, 32'h99, 2'b01, line_of(32'h9000), 1'b1, "R9 evict at done");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "all responses seen", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule